// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block holds one free-running up-counter and a parameterised set of comparator channels, all reached through a flat word-addressed register bus. Software programs a deadline into a channel. When the counter arrives at that deadline, the channel raises its interrupt line, either as a one-clock pulse or as a held level.

A channel that can repeat may run periodically. It keeps a hidden next-deadline register that steps forward by a programmed period on each match, so events recur without further writes. A one-shot channel fires once and must be re-armed. Level-mode channels record their events in a shared status word, which software clears by writing ones.

Register word addresses are fixed as follows:
- 0: read-only capability word.
- 1: global control, bit 0 is the counter run bit.
- 2: the counter.
- 3: the level status word.
- Channel c uses address 8+2c for its control and 8+2c+1 for its compare value.

The compare address reads back the channel's current deadline.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset the counter, the run bit, the status word and all interrupt outputs are zero, and each channel control reads zero except bit 3, which shows whether that channel can repeat.
- R2: The counter rises by exactly one per clock while the run bit is set and otherwise holds. A write to address 2 loads the counter only while the run bit is clear and is ignored while it is set.
- R3: The capability word at address 0 holds the channel count minus one in bits 4:0, a one in bit 5 when the counter is 64 bits wide, and the counter tick period in femtoseconds in bits 31:6.
- R4: A one-shot edge-mode channel with interrupt enable (control bit 1) set drives a single one-clock pulse on its interrupt output, in the clock after the counter holds its compare value, and does not fire again.
- R5: With the repeat bit (control bit 2) and the value-set bit (control bit 4) written together, the next compare write sets the first deadline and the following compare write sets the period. Events then recur exactly one period apart.
- R6: The value-set bit reads back as zero and is consumed by one compare write. Any later compare write to a repeating channel changes only the period.
- R7: A level-mode channel (control bit 0 set) sets status bit c on a match. Its output is high while that bit and interrupt enable are both set. Writing a one to the bit clears it, and writing a zero has no effect.
- R8: On a channel that cannot repeat, the repeat bit reads back as zero and the channel behaves as one-shot, with every compare write setting the deadline.
- R9: With the narrow-compare bit (control bit 5) set, only the low 32 bits of counter and deadline are compared, stored deadlines lose their upper 32 bits, and the periodic advance wraps at 32 bits.
- R10: With interrupt enable clear, the output stays low, but matches still set the level status bit and still advance a repeating channel's deadline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq | output | NCH | One interrupt line per channel |

## Verification
A match is decided in the cycle the counter register holds the deadline. The edge pulse and the status bit are both registered at that clock edge, so each appears one clock after the matching counter value and, for a pulse, lasts exactly one clock. Register writes take effect at the edge that captures them, and read data is combinational, so a read sampled at the next falling edge already shows the new value. The bench drives at falling edges and sets a behavioural model's expected interrupt vector at every rising edge. It compares that vector against the outputs at each falling edge and also checks pulse spacing and counter deltas counted in whole clocks.

// File: rtl/cet_pkg.sv
package cet_pkg;
   // register word addresses
   localparam int unsigned ADDR_CAP     = 0;
   localparam int unsigned ADDR_GCFG    = 1;
   localparam int unsigned ADDR_CNT     = 2;
   localparam int unsigned ADDR_STAT    = 3;
   localparam int unsigned ADDR_CH_BASE = 8;

   // channel control bit positions
   localparam int unsigned CB_LEVEL = 0;
   localparam int unsigned CB_IE    = 1;
   localparam int unsigned CB_PER   = 2;
   localparam int unsigned CB_PCAP  = 3;
   localparam int unsigned CB_VSET  = 4;
   localparam int unsigned CB_M32   = 5;

   localparam int unsigned CFG_W      = 8;
   localparam int unsigned TICK_FLD_W = 26;
endpackage

// File: rtl/cet_main_counter.sv
module cet_main_counter #(
   parameter int unsigned CNT_W = 64
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] value
);
   // running takes priority: a load is honoured only while stopped
   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= '0;
      else if (run)
         value <= value + CNT_W'(1);
      else if (load)
         value <= load_val;
   end
endmodule

// File: rtl/cet_channel.sv
module cet_channel
   import cet_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter bit          PER_CAP = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_run,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cfg_wr,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_word,
   output logic [CNT_W-1:0] target,
   output logic             level_mode,
   output logic             irq_en,
   output logic             periodic,
   output logic             hit,
   output logic             pulse
);
   localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'({32{1'b1}});

   logic             lvl_q, ie_q, per_q, m32_q, pulse_q;
   logic [CNT_W-1:0] tgt_q, cmp_mask, next_tgt;
   logic             load_tgt, advance;

   assign cmp_mask = m32_q ? LOW_MASK : '1;
   assign hit      = cnt_run && ((cnt_val & cmp_mask) == (tgt_q & cmp_mask));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         ie_q  <= 1'b0;
         per_q <= 1'b0;
         m32_q <= 1'b0;
      end else if (cfg_wr) begin
         lvl_q <= wdata[CB_LEVEL];
         ie_q  <= wdata[CB_IE];
         per_q <= wdata[CB_PER] & PER_CAP;
         m32_q <= wdata[CB_M32];
      end
   end

   generate
      if (PER_CAP) begin : g_periodic
         logic [CNT_W-1:0] prd_q;
         logic             pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prd_q  <= '0;
               pend_q <= 1'b0;
            end else begin
               if (cfg_wr)
                  pend_q <= wdata[CB_VSET] & wdata[CB_PER];
               else if (cmp_wr && per_q)
                  pend_q <= 1'b0;
               if (cmp_wr && per_q && !pend_q)
                  prd_q <= wdata & cmp_mask;
            end
         end
         assign load_tgt = cmp_wr && (!per_q || pend_q);
         assign advance  = hit && per_q;
         assign next_tgt = (tgt_q + prd_q) & cmp_mask;
      end else begin : g_single
         assign load_tgt = cmp_wr;
         assign advance  = 1'b0;
         assign next_tgt = tgt_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         tgt_q <= '0;
      else if (load_tgt)
         tgt_q <= wdata & cmp_mask;
      else if (advance)
         tgt_q <= next_tgt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pulse_q <= 1'b0;
      else
         pulse_q <= hit & ie_q & ~lvl_q;
   end

   assign cfg_word   = CFG_W'({m32_q, 1'b0, PER_CAP, per_q, ie_q, lvl_q});
   assign target     = tgt_q;
   assign level_mode = lvl_q;
   assign irq_en     = ie_q;
   assign periodic   = per_q;
   assign pulse      = pulse_q;
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
   import cet_pkg::*;
#(
   parameter int unsigned NCH          = 3,
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned AW           = 6,
   parameter int unsigned TICK_FS      = 20_000_000,
   parameter logic [31:0] PER_CAP_MASK = 32'h0000_0003
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic [NCH-1:0]   irq
);
   localparam logic [31:0] CAP_WORD =
      {TICK_FLD_W'(TICK_FS), (CNT_W == 64) ? 1'b1 : 1'b0, 5'(NCH - 1)};

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("cmp_event_timer: NCH must lie in 1..32");
      end
      if (CNT_W != 32 && CNT_W != 64) begin : g_bad_width
         $error("cmp_event_timer: CNT_W must be 32 or 64");
      end
      if (ADDR_CH_BASE + 2 * NCH > (1 << AW)) begin : g_bad_aw
         $error("cmp_event_timer: AW too narrow for the channel registers");
      end
      if (TICK_FS >= (1 << TICK_FLD_W)) begin : g_bad_tick
         $error("cmp_event_timer: TICK_FS does not fit its capability field");
      end
   endgenerate

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NCH-1:0]   status_q, hit_v, lvl_v, ie_v, per_v, pulse_v;
   logic [CNT_W-1:0] ch_tgt [NCH];
   logic [CFG_W-1:0] ch_cfg [NCH];
   logic             gcfg_wr, cnt_wr, stat_wr;

   assign gcfg_wr = bus_wr && (bus_addr == AW'(ADDR_GCFG));
   assign cnt_wr  = bus_wr && (bus_addr == AW'(ADDR_CNT));
   assign stat_wr = bus_wr && (bus_addr == AW'(ADDR_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (gcfg_wr)
         en_q <= bus_wdata[0];
   end

   cet_main_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en_q),
      .load     (cnt_wr),
      .load_val (bus_wdata),
      .value    (cnt_q)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic cfg_sel, cmp_sel;
         assign cfg_sel = bus_wr && (bus_addr == AW'(ADDR_CH_BASE + 2 * c));
         assign cmp_sel = bus_wr && (bus_addr == AW'(ADDR_CH_BASE + 2 * c + 1));

         cet_channel #(
            .CNT_W   (CNT_W),
            .PER_CAP (PER_CAP_MASK[c])
         ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_run    (en_q),
            .cnt_val    (cnt_q),
            .cfg_wr     (cfg_sel),
            .cmp_wr     (cmp_sel),
            .wdata      (bus_wdata),
            .cfg_word   (ch_cfg[c]),
            .target     (ch_tgt[c]),
            .level_mode (lvl_v[c]),
            .irq_en     (ie_v[c]),
            .periodic   (per_v[c]),
            .hit        (hit_v[c]),
            .pulse      (pulse_v[c])
         );
      end
   endgenerate

   // shared level status: a new event wins over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= (hit_v & lvl_v) |
                     (status_q & ~({NCH{stat_wr}} & bus_wdata[NCH-1:0]));
   end

   assign irq = pulse_v | (status_q & ie_v & lvl_v);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(ADDR_CAP))  bus_rdata = CNT_W'(CAP_WORD);
      if (bus_addr == AW'(ADDR_GCFG)) bus_rdata = CNT_W'(en_q);
      if (bus_addr == AW'(ADDR_CNT))  bus_rdata = cnt_q;
      if (bus_addr == AW'(ADDR_STAT)) bus_rdata = CNT_W'(status_q);
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == AW'(ADDR_CH_BASE + 2 * c))     bus_rdata = CNT_W'(ch_cfg[c]);
         if (bus_addr == AW'(ADDR_CH_BASE + 2 * c + 1)) bus_rdata = ch_tgt[c];
      end
   end
endmodule

// File: rtl/cet_checker.sv
module cet_checker #(
   parameter int unsigned NCH          = 3,
   parameter int unsigned CNT_W        = 64,
   parameter logic [31:0] PER_CAP_MASK = 32'h0000_0003
)(
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             cnt_wr,
   input logic             stat_wr,
   input logic [NCH-1:0]   clr_bits,
   input logic [CNT_W-1:0] cnt_q,
   input logic [NCH-1:0]   status_q,
   input logic [NCH-1:0]   hit_v,
   input logic [NCH-1:0]   lvl_v,
   input logic [NCH-1:0]   ie_v,
   input logic [NCH-1:0]   per_v
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));   // R2

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cnt_wr) |=> $stable(cnt_q));           // R2

   AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && (&clr_bits) && !(|(hit_v & lvl_v))) |=> (status_q == '0));   // R7

   AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q == '0) && !(|(hit_v & lvl_v))) |=> (status_q == '0));   // R7

   AST_LATCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hit_v & lvl_v & ~ie_v)) |=>
         ((status_q & $past(hit_v & lvl_v & ~ie_v)) == $past(hit_v & lvl_v & ~ie_v)));   // R10

   AST_NO_CAP_PER: assert property (@(posedge clk) disable iff (!rst_n)
      ((per_v & ~PER_CAP_MASK[NCH-1:0]) == '0));   // R8
endmodule

bind cmp_event_timer cet_checker #(
   .NCH          (NCH),
   .CNT_W        (CNT_W),
   .PER_CAP_MASK (PER_CAP_MASK)
) u_cet_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_q     (en_q),
   .cnt_wr   (cnt_wr),
   .stat_wr  (stat_wr),
   .clr_bits (bus_wdata[NCH-1:0]),
   .cnt_q    (cnt_q),
   .status_q (status_q),
   .hit_v    (hit_v),
   .lvl_v    (lvl_v),
   .ie_v     (ie_v),
   .per_v    (per_v)
);

// File: tb/cmp_event_timer_bench.sv
module cmp_event_timer_bench;
   localparam int NCH   = 3;
   localparam int CNT_W = 64;
   localparam int AW    = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic [AW-1:0]    bus_addr = '0;
   logic [CNT_W-1:0] bus_wdata = '0;
   logic [CNT_W-1:0] bus_rdata;
   logic [NCH-1:0]   irq;

   int  n_vec = 0;
   int  n_err = 0;
   bit  done = 1'b0;
   bit  model_on = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   cmp_event_timer #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW)) u_cmp_event_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [63:0] m_cnt;
   bit          m_en;
   bit          m_lvl [NCH], m_ie [NCH], m_per [NCH], m_m32 [NCH], m_pend [NCH];
   logic [63:0] m_tgt [NCH], m_prd [NCH];
   bit [NCH-1:0] m_stat, m_pulse, m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_en = 0; m_stat = '0; m_pulse = '0; m_irq = '0;
         for (int c = 0; c < NCH; c++) begin
            m_lvl[c] = 0; m_ie[c] = 0; m_per[c] = 0; m_m32[c] = 0; m_pend[c] = 0;
            m_tgt[c] = '0; m_prd[c] = '0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            logic [63:0] msk;
            bit          hit;
            bit          cap;
            cap = (c < 2);
            msk = m_m32[c] ? 64'h0000_0000_FFFF_FFFF : '1;
            hit = m_en && ((m_cnt & msk) == (m_tgt[c] & msk));
            if (hit && m_lvl[c]) m_stat[c] = 1;
            else if (bus_wr && bus_addr == 3 && bus_wdata[c]) m_stat[c] = 0;
            m_pulse[c] = hit && m_ie[c] && !m_lvl[c];
            if (bus_wr && bus_addr == AW'(8 + 2 * c)) begin
               m_lvl[c]  = bus_wdata[0];
               m_ie[c]   = bus_wdata[1];
               m_per[c]  = bus_wdata[2] && cap;
               m_pend[c] = bus_wdata[4] && bus_wdata[2] && cap;
               m_m32[c]  = bus_wdata[5];
            end else if (bus_wr && bus_addr == AW'(9 + 2 * c)) begin
               if (m_per[c] && m_pend[c]) begin m_tgt[c] = bus_wdata & msk; m_pend[c] = 0; end
               else if (m_per[c]) m_prd[c] = bus_wdata & msk;
               else m_tgt[c] = bus_wdata & msk;
            end else if (hit && m_per[c]) begin
               m_tgt[c] = (m_tgt[c] + m_prd[c]) & msk;
            end
         end
         if (m_en) m_cnt = m_cnt + 1;
         else if (bus_wr && bus_addr == 2) m_cnt = bus_wdata;
         if (bus_wr && bus_addr == 1) m_en = bus_wdata[0];
         for (int c = 0; c < NCH; c++)
            m_irq[c] = m_pulse[c] | (m_stat[c] & m_ie[c] & m_lvl[c]);
      end
   end

   // every-cycle comparison of the interrupt vector
   always @(negedge clk) begin
      if (rst_n && model_on && !done) begin
         n_vec++;
         if (irq !== m_irq) begin
            n_err++;
            $display("FAIL R4/R5/R7/R10 cycle irq: got %b exp %b", irq, m_irq);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic wr(input int a, input logic [63:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_get(input int a, output logic [63:0] v);
      @(negedge clk);
      bus_addr = AW'(a);
      #1;
      v = bus_rdata;
   endtask

   task automatic check64(input logic [63:0] got, input logic [63:0] exp, input string tag);
      n_vec++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic rd_chk(input int a, input logic [63:0] exp, input string tag);
      logic [63:0] v;
      rd_get(a, v);
      check64(v, exp, tag);
   endtask

   task automatic count_pulses(input int ch, input int cycles, output int n);
      n = 0;
      repeat (cycles) begin
         @(negedge clk); #1;
         if (irq[ch]) n++;
      end
   endtask

   task automatic gap_chk(input int ch, input int exp_gap, input int npulses, input string tag);
      int last;
      int t;
      int seen;
      last = -1; t = 0; seen = 0;
      while (seen < npulses && t < 400) begin
         @(negedge clk); #1; t++;
         if (irq[ch]) begin
            if (last >= 0) check64(64'(t - last), 64'(exp_gap), tag);
            last = t;
            seen++;
         end
      end
      check64(64'(seen), 64'(npulses), {tag, " pulse count"});
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [63:0] v, v2, first;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_on = 1'b1;

      // R1 reset state
      check64(64'(irq), 64'd0, "R1 irq after reset");
      rd_chk(2, 64'd0, "R1 counter");
      rd_chk(1, 64'd0, "R1 run bit");
      rd_chk(3, 64'd0, "R1 status");
      rd_chk(8, 64'd8, "R1 ch0 control");
      rd_chk(12, 64'd0, "R1 ch2 control");

      // R3 capability word
      rd_chk(0, {32'd0, 26'd20_000_000, 1'b1, 5'd2}, "R3 capability");

      // R2 counter load, hold and run
      wr(2, 64'd100);
      repeat (3) @(negedge clk);
      rd_chk(2, 64'd100, "R2 load while stopped, then hold");
      wr(1, 64'd1);
      rd_get(2, v); rd_get(2, v2);
      check64(v2, v + 1, "R2 one step per clock");
      rd_get(2, v); repeat (4) @(negedge clk); rd_get(2, v2);
      check64(v2, v + 5, "R2 five steps");
      rd_get(2, v); wr(2, 64'd5); rd_get(2, v2);
      check64(v2, v + 3, "R2 write ignored while running");

      // R4 one-shot edge channel 0: pulse once, with counter at deadline+1
      wr(8, 64'd2);
      rd_get(2, v);
      wr(9, v + 12);
      bus_addr = AW'(2);
      n = 0;
      repeat (30) begin
         @(negedge clk); #1;
         if (irq[0]) begin
            n++;
            check64(bus_rdata, v + 13, "R4 pulse one clock after match");
         end
      end
      check64(64'(n), 64'd1, "R4 single pulse");

      // R5 / R6 repeating channel 1 with value-set
      wr(10, 64'd22);
      rd_chk(10, 64'd14, "R6 value-set reads as zero");
      rd_get(2, v);
      wr(11, v + 10);
      wr(11, 64'd7);
      gap_chk(1, 7, 4, "R5 period spacing");
      wr(11, 64'd3);
      gap_chk(1, 3, 4, "R6 later write sets period");
      wr(10, 64'd0);

      // R7 level mode on channel 0
      wr(8, 64'd3);
      rd_get(2, v);
      wr(9, v + 6);
      repeat (10) @(negedge clk);
      rd_chk(3, 64'd1, "R7 status bit set");
      check64(64'(irq[0]), 64'd1, "R7 level output high");
      wr(3, 64'd0);
      rd_chk(3, 64'd1, "R7 zero write has no effect");
      wr(3, 64'd1);
      rd_chk(3, 64'd0, "R7 write one clears");
      check64(64'(irq[0]), 64'd0, "R7 level output low after clear");
      wr(8, 64'd0);

      // R10 masked repeating level channel 1
      wr(10, 64'd21);
      rd_get(2, v);
      first = v + 6;
      wr(11, first);
      wr(11, 64'd4);
      repeat (12) @(negedge clk);
      rd_chk(3, 64'd2, "R10 status latches while masked");
      check64(64'(irq[1]), 64'd0, "R10 output masked");
      rd_get(11, v2);
      check64(64'((v2 > first) && ((v2 - first) % 4 == 0)), 64'd1, "R10 deadline advanced");
      wr(10, 64'd0);
      wr(3, 64'd7);
      rd_chk(3, 64'd0, "R10 status cleared");

      // R8 repeat bit ignored on channel 2
      wr(12, 64'd6);
      rd_chk(12, 64'd2, "R8 repeat bit reads zero");
      wr(13, 64'd3);
      rd_get(2, v);
      wr(13, v + 6);
      count_pulses(2, 40, n);
      check64(64'(n), 64'd1, "R8 one-shot behaviour");
      wr(12, 64'd0);

      // R9 narrow compare on channel 0
      wr(1, 64'd0);
      wr(2, 64'h0000_0001_FFFF_FFF0);
      wr(8, 64'd34);
      wr(9, 64'h0000_0007_0000_0004);
      rd_chk(9, 64'd4, "R9 deadline upper bits dropped");
      wr(1, 64'd1);
      count_pulses(0, 40, n);
      check64(64'(n), 64'd1, "R9 low-half match");
      wr(8, 64'd0);

      // R9 accumulator wrap on channel 1
      wr(1, 64'd0);
      wr(2, 64'h0000_0000_FFFF_FFE0);
      wr(10, 64'd54);
      wr(11, 64'h0000_0000_FFFF_FFF0);
      wr(11, 64'd16);
      wr(1, 64'd1);
      repeat (22) @(negedge clk);
      rd_chk(11, 64'd0, "R9 accumulator wraps at 32 bits");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_err++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end
endmodule